// File: doc/BRIEF.md
# Debug Watchpoint Comparator Unit

This block watches the processor's instruction fetch stream and its load/store stream and flags accesses that satisfy programmable conditions. It holds eight comparators: comparators 0 to 3 look at the fetch address, comparators 4 and 5 look at the load/store address, and comparators 6 and 7 look at the load/store data value. Each comparator has a reference value and a control word. The control word selects one of four unsigned conditions, enables the comparator and says whether a hit should request a breakpoint.

A hit produces a registered event pulse on the comparator's own output bit and sets a sticky status bit. Software clears a status bit by writing 1 to it. Hits on comparators whose breakpoint bit is set also raise a single breakpoint request line in the same cycle as the event. Halting the core and the link to a debug host sit outside this block.

Top module: `wpt_top`

## Requirements
- R1: After reset every reference register, every control word and every status bit reads 0, and `wp_event` and `break_req` are 0.
- R2: Register map on `reg_addr`: addresses 0..7 hold the reference of comparator 0..7 (full width, read/write). Addresses 8..15 hold the control word of comparator 0..7: bits [1:0] condition, bit 2 enable, bit 3 breakpoint enable; the other bits read 0. Address 16 is the status register, one bit per comparator. Any other address reads 0. Reads are combinational.
- R3: Condition codes: 00 hits when value equals reference, 01 when not equal, 10 when value is below reference, 11 when value is above reference. Comparison is unsigned.
- R4: Comparators 0..3 compare `fetch_addr` and are evaluated only in cycles with `fetch_valid` high; the load/store inputs never cause them to hit.
- R5: Comparators 4 and 5 compare `ls_addr`, comparators 6 and 7 compare `ls_data`; both groups are evaluated only in cycles with `ls_valid` high, and fetch inputs never cause them to hit.
- R6: A hit on an access sampled at clock edge k drives the comparator's bit of `wp_event` high for the cycle after edge k only, unless the next access also hits.
- R7: A comparator whose enable bit is 0 produces no event, no status bit and no breakpoint request.
- R8: A status bit is set at the same edge its event rises and stays set until a write to address 16 with 1 in that bit position. Writing 0 leaves it unchanged. A hit and a clear in the same cycle leave the bit set.
- R9: `break_req` is high in exactly the cycles in which at least one comparator with its breakpoint enable bit set has its event high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| fetch_valid | input | 1 | Fetch access qualifier |
| fetch_addr | input | 32 | Instruction fetch address |
| ls_valid | input | 1 | Load/store access qualifier |
| ls_addr | input | 32 | Load/store address |
| ls_data | input | 32 | Load/store data value |
| wp_event | output | 8 | Per-comparator registered hit pulse |
| break_req | output | 1 | Internal breakpoint request |

## Verification
A wrong condition decode or a comparator wired to the wrong source shows on `wp_event` one cycle after the offending access, so each directed access is checked on the next cycle and again one cycle later to catch a pulse that does not end. Corrupted reference or control storage appears immediately on `reg_rdata`, and a status bit that is lost, stuck or cleared by the wrong mask appears on the next read of address 16. A breakpoint gating fault shows on `break_req` in the same cycle as the event it should follow.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

    typedef enum logic [1:0] {
        CMP_EQ = 2'b00,
        CMP_NE = 2'b01,
        CMP_LT = 2'b10,
        CMP_GT = 2'b11
    } cond_e;

    typedef enum logic [1:0] {
        SRC_FETCH_ADDR = 2'd0,
        SRC_LS_ADDR    = 2'd1,
        SRC_LS_DATA    = 2'd2
    } src_e;

    typedef struct packed {
        logic  brk_en;
        logic  en;
        cond_e cond;
    } wp_ctrl_t;

    localparam int CTRL_W = $bits(wp_ctrl_t);

    // Resolve a condition from the equal / below flags of one compare.
    function automatic logic cond_hit(cond_e c, logic is_eq, logic is_lt);
        logic r;
        unique case (c)
            CMP_EQ:  r = is_eq;
            CMP_NE:  r = !is_eq;
            CMP_LT:  r = is_lt;
            default: r = !is_lt && !is_eq;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wpt_regs.sv
module wpt_regs
    import wpt_pkg::*;
#(
    parameter int N_CMP  = 8,
    parameter int WIDTH  = 32,
    parameter int REG_AW = 5
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [REG_AW-1:0]                wr_addr,
    input  logic [WIDTH-1:0]                 wr_data,
    output logic [N_CMP-1:0][WIDTH-1:0]      refs_o,
    output wp_ctrl_t [N_CMP-1:0]             ctrl_o
);

    localparam int CTRL_BASE = N_CMP;

    logic [N_CMP-1:0][WIDTH-1:0] refs_q;
    wp_ctrl_t [N_CMP-1:0]        ctrl_q;

    for (genvar g = 0; g < N_CMP; g++) begin : g_slot
        localparam logic [REG_AW-1:0] REF_A  = REG_AW'(g);
        localparam logic [REG_AW-1:0] CTRL_A = REG_AW'(CTRL_BASE + g);

        always_ff @(posedge clk) begin
            if (rst) begin
                refs_q[g] <= '0;
                ctrl_q[g] <= '0;
            end else if (wr_en) begin
                if (wr_addr == REF_A)
                    refs_q[g] <= wr_data;
                if (wr_addr == CTRL_A)
                    ctrl_q[g] <= wp_ctrl_t'(wr_data[CTRL_W-1:0]);
            end
        end
    end

    assign refs_o = refs_q;
    assign ctrl_o = ctrl_q;

    // R2
    ref_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == REG_AW'(0)) |=> (refs_o[0] == $past(wr_data)));

endmodule

// File: rtl/wpt_cmp.sv
module wpt_cmp
    import wpt_pkg::*;
#(
    parameter int   WIDTH = 32,
    parameter src_e SRC   = SRC_FETCH_ADDR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_valid,
    input  logic [WIDTH-1:0] fetch_addr,
    input  logic             ls_valid,
    input  logic [WIDTH-1:0] ls_addr,
    input  logic [WIDTH-1:0] ls_data,
    input  logic [WIDTH-1:0] ref_val,
    input  wp_ctrl_t         ctrl,
    output logic             hit_d,
    output logic             hit_q,
    output logic             brk_q
);

    logic             qual;
    logic [WIDTH-1:0] sample;
    logic             is_eq;
    logic             is_lt;

    if (SRC == SRC_FETCH_ADDR) begin : g_fetch
        assign qual   = fetch_valid;
        assign sample = fetch_addr;
    end else if (SRC == SRC_LS_ADDR) begin : g_lsaddr
        assign qual   = ls_valid;
        assign sample = ls_addr;
    end else begin : g_lsdata
        assign qual   = ls_valid;
        assign sample = ls_data;
    end

    always_comb begin
        is_eq = (sample == ref_val);
        is_lt = (sample < ref_val);
        hit_d = qual && ctrl.en && cond_hit(ctrl.cond, is_eq, is_lt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
            brk_q <= 1'b0;
        end else begin
            hit_q <= hit_d;
            brk_q <= hit_d && ctrl.brk_en;
        end
    end

    // R4
    qual_src_chk: assert property (@(posedge clk) disable iff (rst)
        hit_q |-> $past(qual));

    // R9
    brk_follow_chk: assert property (@(posedge clk) disable iff (rst)
        brk_q |-> hit_q);

endmodule

// File: rtl/wpt_status.sv
module wpt_status #(
    parameter int N_CMP = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CMP-1:0] hit_d,
    input  logic [N_CMP-1:0] brk_q,
    input  logic [N_CMP-1:0] clr_mask,
    output logic [N_CMP-1:0] status_o,
    output logic             break_o
);

    logic [N_CMP-1:0] status_q;

    always_ff @(posedge clk) begin
        if (rst)
            status_q <= '0;
        else
            status_q <= (status_q & ~clr_mask) | hit_d;
    end

    assign status_o = status_q;
    assign break_o  = |brk_q;

    for (genvar g = 0; g < N_CMP; g++) begin : g_chk
        // R8
        sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $fell(status_q[g])) |-> $past(clr_mask[g]));
    end

endmodule

// File: rtl/wpt_top.sv
module wpt_top
    import wpt_pkg::*;
#(
    parameter int  WIDTH   = 32,
    parameter int  N_IADDR = 4,
    parameter int  N_DADDR = 2,
    parameter int  N_DVAL  = 2,
    localparam int N_CMP   = N_IADDR + N_DADDR + N_DVAL,
    localparam int REG_AW  = $clog2(2 * N_CMP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WIDTH-1:0]  reg_wdata,
    output logic [WIDTH-1:0]  reg_rdata,
    input  logic              fetch_valid,
    input  logic [WIDTH-1:0]  fetch_addr,
    input  logic              ls_valid,
    input  logic [WIDTH-1:0]  ls_addr,
    input  logic [WIDTH-1:0]  ls_data,
    output logic [N_CMP-1:0]  wp_event,
    output logic              break_req
);

    localparam logic [REG_AW-1:0] STAT_A = REG_AW'(2 * N_CMP);

    logic [N_CMP-1:0][WIDTH-1:0] refs;
    wp_ctrl_t [N_CMP-1:0]        ctrl;
    logic [N_CMP-1:0]            hit_d;
    logic [N_CMP-1:0]            hit_q;
    logic [N_CMP-1:0]            brk_q;
    logic [N_CMP-1:0]            clr_mask;
    logic [N_CMP-1:0]            status;

    wpt_regs #(
        .N_CMP (N_CMP),
        .WIDTH (WIDTH),
        .REG_AW(REG_AW)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr_en),
        .wr_addr(reg_addr),
        .wr_data(reg_wdata),
        .refs_o (refs),
        .ctrl_o (ctrl)
    );

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        localparam src_e SRC = (g < N_IADDR)           ? SRC_FETCH_ADDR :
                               (g < N_IADDR + N_DADDR) ? SRC_LS_ADDR    :
                                                         SRC_LS_DATA;
        wpt_cmp #(
            .WIDTH(WIDTH),
            .SRC  (SRC)
        ) u_cmp (
            .clk        (clk),
            .rst        (rst),
            .fetch_valid(fetch_valid),
            .fetch_addr (fetch_addr),
            .ls_valid   (ls_valid),
            .ls_addr    (ls_addr),
            .ls_data    (ls_data),
            .ref_val    (refs[g]),
            .ctrl       (ctrl[g]),
            .hit_d      (hit_d[g]),
            .hit_q      (hit_q[g]),
            .brk_q      (brk_q[g])
        );

        // R7
        off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(ctrl[g].en) |-> !wp_event[g]);

        // R8
        status_set_chk: assert property (@(posedge clk) disable iff (rst)
            wp_event[g] |-> status[g]);
    end

    assign clr_mask = (reg_wr_en && reg_addr == STAT_A) ? reg_wdata[N_CMP-1:0] : '0;

    wpt_status #(
        .N_CMP(N_CMP)
    ) u_status (
        .clk     (clk),
        .rst     (rst),
        .hit_d   (hit_d),
        .brk_q   (brk_q),
        .clr_mask(clr_mask),
        .status_o(status),
        .break_o (break_req)
    );

    assign wp_event = hit_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr < REG_AW'(N_CMP))
            reg_rdata = refs[reg_addr[$clog2(N_CMP)-1:0]];
        else if (reg_addr < STAT_A)
            reg_rdata = WIDTH'(ctrl[reg_addr[$clog2(N_CMP)-1:0]]);
        else if (reg_addr == STAT_A)
            reg_rdata = WIDTH'(status);
    end

    // R9
    brk_event_chk: assert property (@(posedge clk) disable iff (rst)
        break_req |-> (|wp_event));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (wp_event == '0 && !break_req));

endmodule

// File: tb/sim_wpt_top.sv
module sim_wpt_top;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int ST = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr_en = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  reg_rdata;
    logic          fetch_valid = 1'b0;
    logic [W-1:0]  fetch_addr = '0;
    logic          ls_valid = 1'b0;
    logic [W-1:0]  ls_addr = '0;
    logic [W-1:0]  ls_data = '0;
    logic [7:0]    wp_event;
    logic          break_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wpt_top u0 (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .ls_valid(ls_valid), .ls_addr(ls_addr),
        .ls_data(ls_data), .wp_event(wp_event), .break_req(break_req)
    );

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [W-1:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [W-1:0] d);
        @(negedge clk);
        reg_addr = 5'(a);
        #1 d = reg_rdata;
    endtask

    // Ctrl word: bits[1:0] cond, bit2 enable, bit3 break enable.
    function automatic logic [W-1:0] cw(int cond, bit en, bit brk);
        return W'({brk, en, 2'(cond)});
    endfunction

    task automatic fetch(logic [W-1:0] a);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = a;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic lsacc(logic [W-1:0] a, logic [W-1:0] d);
        @(negedge clk);
        ls_valid = 1'b1; ls_addr = a; ls_data = d;
        @(negedge clk);
        ls_valid = 1'b0;
    endtask

    task automatic quiesce();
        for (int i = 0; i < 8; i++) wr(8 + i, '0);
        wr(ST, 32'hFF);
    endtask

    task automatic t_reset();
        logic [W-1:0] d;
        chk("R1 event", W'(wp_event), 0);
        chk("R1 break", W'(break_req), 0);
        rd(ST, d);  chk("R1 status", d, 0);
        rd(3, d);   chk("R1 ref", d, 0);
        rd(13, d);  chk("R1 ctrl", d, 0);
    endtask

    task automatic t_regs();
        logic [W-1:0] d;
        wr(2, 32'hDEADBEEF);
        rd(2, d);  chk("R2 ref rw", d, 32'hDEADBEEF);
        wr(12, 32'hFFFF_FFFF);
        rd(12, d); chk("R2 ctrl width", d, 32'h0000_000F);
        rd(20, d); chk("R2 unmapped", d, 0);
        wr(12, '0);
    endtask

    function automatic bit exp_hit(int c, logic [W-1:0] v, logic [W-1:0] r);
        case (c)
            0: return v == r;
            1: return v != r;
            2: return v < r;
            default: return v > r;
        endcase
    endfunction

    task automatic t_cond();
        logic [W-1:0] vals[4] = '{32'h0FFF, 32'h1000, 32'h1001, 32'h8000_0000};
        wr(0, 32'h1000);
        for (int c = 0; c < 4; c++) begin
            wr(8, cw(c, 1'b1, 1'b0));
            for (int k = 0; k < 4; k++) begin
                fetch(vals[k]);
                chk($sformatf("R3 cond%0d val%h", c, vals[k]), W'(wp_event[0]),
                    W'(exp_hit(c, vals[k], 32'h1000)));
                @(negedge clk);
                chk("R6 pulse end", W'(wp_event[0]), 0);
            end
        end
        quiesce();
    endtask

    task automatic t_qual();
        wr(0, 32'hA0);  wr(8, cw(0, 1'b1, 1'b0));
        wr(4, 32'hB0);  wr(12, cw(0, 1'b1, 1'b0));
        wr(6, 32'hC0);  wr(14, cw(0, 1'b1, 1'b0));
        @(negedge clk);
        fetch_addr = 32'hA0; fetch_valid = 1'b0;
        @(negedge clk);
        chk("R4 no valid", W'(wp_event), 0);
        lsacc(32'hA0, 32'hA0);
        chk("R4 ls ignored", W'(wp_event), 0);
        lsacc(32'hB0, 32'hC0);
        chk("R5 ls addr+data", W'(wp_event), W'(8'h50));
        fetch(32'hB0);
        chk("R5 fetch ignored", W'(wp_event), 0);
        lsacc(32'hC0, 32'hB0);
        chk("R5 src swap", W'(wp_event), 0);
        fetch(32'hA0);
        chk("R4 fetch hit", W'(wp_event), W'(8'h01));
        quiesce();
    endtask

    task automatic t_back2back();
        wr(1, 32'h40); wr(9, cw(0, 1'b1, 1'b0));
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = 32'h40;
        @(negedge clk);
        chk("R6 first", W'(wp_event[1]), 1);
        fetch_addr = 32'h44;
        @(negedge clk);
        fetch_valid = 1'b0;
        chk("R6 second miss", W'(wp_event[1]), 0);
        quiesce();
    endtask

    task automatic t_disable();
        logic [W-1:0] d;
        wr(1, 32'h77); wr(9, cw(0, 1'b0, 1'b1));
        fetch(32'h77);
        chk("R7 no event", W'(wp_event), 0);
        chk("R7 no break", W'(break_req), 0);
        rd(ST, d); chk("R7 no status", d, 0);
        quiesce();
    endtask

    task automatic t_sticky();
        logic [W-1:0] d;
        wr(0, 32'h10); wr(8, cw(0, 1'b1, 1'b0));
        wr(5, 32'h20); wr(13, cw(0, 1'b1, 1'b0));
        fetch(32'h10);
        lsacc(32'h20, 0);
        rd(ST, d); chk("R8 set", d, 32'h21);
        wr(ST, 32'h00);
        rd(ST, d); chk("R8 write0", d, 32'h21);
        wr(ST, 32'h01);
        rd(ST, d); chk("R8 clear one", d, 32'h20);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 5'(ST); reg_wdata = 32'h21;
        fetch_valid = 1'b1; fetch_addr = 32'h10;
        @(negedge clk);
        reg_wr_en = 1'b0; fetch_valid = 1'b0;
        chk("R8 same-cycle event", W'(wp_event), W'(8'h01));
        rd(ST, d); chk("R8 set wins", d, 32'h01);
        quiesce();
    endtask

    task automatic t_break();
        wr(2, 32'h300); wr(10, cw(0, 1'b1, 1'b1));
        wr(3, 32'h300); wr(11, cw(0, 1'b1, 1'b0));
        wr(7, 32'h5);   wr(15, cw(3, 1'b1, 1'b0));
        fetch(32'h300);
        chk("R9 break on", W'(break_req), 1);
        chk("R9 events", W'(wp_event), W'(8'h0C));
        @(negedge clk);
        chk("R9 break off", W'(break_req), 0);
        wr(10, cw(0, 1'b0, 1'b1));
        fetch(32'h300);
        chk("R9 no brk comp", W'(break_req), 0);
        chk("R9 event only", W'(wp_event), W'(8'h08));
        lsacc(0, 32'h9);
        chk("R9 data gt no brk", W'(break_req), 0);
        chk("R3 data gt", W'(wp_event), W'(8'h80));
        quiesce();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_cond();
        t_qual();
        t_back2back();
        t_disable();
        t_sticky();
        t_break();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule